// File: doc/BRIEF.md
# One-Position Bidirectional Result Shifter

This block sits on the path from the arithmetic/logic unit result to the output bus. It takes the full-width result word and, under a two-bit operation code, either forwards it unchanged, moves it one place toward the least significant end, moves it one place toward the most significant end, or blocks it so that the bus sees zero. The whole path is multiplexers, one per output bit, so the shifted word is ready in the same cycle as the result with no register on the way.

The bit that enters the vacated end of a shifted word comes from a separate fill control: with that control low the fill is zero, with it high the fill is the current carry flag, which lets a carry be moved into the word during a shift. The block holds no state.

Top module: `combo_shift_unit`

## Requirements
- R1: With `shift_op` = 2'b00 the output `bus_out` equals `alu_res` bit for bit.
- R2: With `shift_op` = 2'b01 (right shift) `bus_out[i]` equals `alu_res[i+1]` for every i below the MSB, and the old LSB is discarded.
- R3: With `shift_op` = 2'b10 (left shift) `bus_out[i]` equals `alu_res[i-1]` for every i above the LSB, and the old MSB is discarded.
- R4: With `shift_op` = 2'b11 `bus_out` is all zeros whatever `alu_res`, `fill_from_carry` and `carry_in` are.
- R5: With `fill_from_carry` = 0 the bit entering the vacated end (the MSB on a right shift, the LSB on a left shift) is 0 regardless of `carry_in`.
- R6: With `fill_from_carry` = 1 the bit entering the vacated end (the MSB on a right shift, the LSB on a left shift) equals `carry_in`.
- R7: With `shift_op` = 2'b00 or 2'b11, `fill_from_carry` and `carry_in` have no effect on `bus_out`.
- R8: `bus_out` is a pure function of the present inputs: it settles within the cycle the inputs change and repeating an input set repeats the output, whatever came before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_res | input | WIDTH | Result word from the arithmetic/logic unit |
| shift_op | input | 2 | 00 pass, 01 right by one, 10 left by one, 11 block |
| fill_from_carry | input | 1 | 0: fill with zero; 1: fill with the carry flag |
| carry_in | input | 1 | Current carry flag from the status register |
| bus_out | output | WIDTH | Word placed on the output bus |

## Verification
Every result word of the default width is driven under all four operation codes and both settings of each fill control, which separates a correct neighbour wiring from a swapped or off-by-one one and shows the fill landing at the right end only. Directed words with a lone set bit at the MSB or LSB show that the end bit leaving a shift is lost rather than wrapped around, and alternating patterns such as 0x55 and 0xAA tell a right shift from a left one at a glance. Changing only the fill controls while passing or blocking shows they leave the output untouched, and re-applying an earlier input set after different ones shows there is no memory.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;

    typedef enum logic [1:0] {
        SH_PASS  = 2'b00,
        SH_RIGHT = 2'b01,
        SH_LEFT  = 2'b10,
        SH_BLOCK = 2'b11
    } shift_op_e;

    typedef struct packed {
        shift_op_e op;
        logic      use_carry;
    } shift_ctrl_t;

    function automatic logic pick_fill(input logic use_carry, input logic carry);
        return use_carry ? carry : 1'b0;
    endfunction

endpackage

// File: rtl/shift_fill_gen.sv
module shift_fill_gen
    import shift_unit_pkg::*;
(
    input  logic use_carry,
    input  logic carry,
    output logic fill
);
    always_comb fill = pick_fill(use_carry, carry);
endmodule

// File: rtl/shift_bit_mux.sv
module shift_bit_mux
    import shift_unit_pkg::*;
(
    input  shift_op_e op,
    input  logic      own_bit,
    input  logic      upper_bit,
    input  logic      lower_bit,
    output logic      out_bit
);
    always_comb begin
        case (op)
            SH_PASS:  out_bit = own_bit;
            SH_RIGHT: out_bit = upper_bit;
            SH_LEFT:  out_bit = lower_bit;
            default:  out_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/combo_shift_unit.sv
module combo_shift_unit
    import shift_unit_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] alu_res,
    input  logic [1:0]       shift_op,
    input  logic             fill_from_carry,
    input  logic             carry_in,
    output logic [WIDTH-1:0] bus_out
);
    localparam int MSB = WIDTH - 1;

    shift_ctrl_t ctrl;
    logic        fill_bit;

    always_comb begin
        ctrl.op        = shift_op_e'(shift_op);
        ctrl.use_carry = fill_from_carry;
    end

    shift_fill_gen u_fill (
        .use_carry (ctrl.use_carry),
        .carry     (carry_in),
        .fill      (fill_bit)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic up_src;
        logic dn_src;
        if (i == MSB) begin : g_top
            assign up_src = fill_bit;
        end else begin : g_mid_up
            assign up_src = alu_res[i+1];
        end
        if (i == 0) begin : g_bot
            assign dn_src = fill_bit;
        end else begin : g_mid_dn
            assign dn_src = alu_res[i-1];
        end
        shift_bit_mux u_mux (
            .op        (ctrl.op),
            .own_bit   (alu_res[i]),
            .upper_bit (up_src),
            .lower_bit (dn_src),
            .out_bit   (bus_out[i])
        );
    end
endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] alu_res,
    input logic [1:0]       shift_op,
    input logic             fill_from_carry,
    input logic             carry_in,
    input logic [WIDTH-1:0] bus_out
);
    always_comb begin
        if (shift_op == 2'b00) begin
            a_r1_pass_through: assert (bus_out == alu_res)
                else $error("R1 pass mismatch");
        end
        if (shift_op == 2'b01) begin
            a_r2_right_body: assert (bus_out[WIDTH-2:0] == alu_res[WIDTH-1:1])
                else $error("R2 right body mismatch");
            a_r6_right_fill: assert (bus_out[WIDTH-1] == (fill_from_carry & carry_in))
                else $error("R5/R6 right fill mismatch");
        end
        if (shift_op == 2'b10) begin
            a_r3_left_body: assert (bus_out[WIDTH-1:1] == alu_res[WIDTH-2:0])
                else $error("R3 left body mismatch");
            a_r5_left_fill: assert (bus_out[0] == (fill_from_carry & carry_in))
                else $error("R5/R6 left fill mismatch");
        end
        if (shift_op == 2'b11) begin
            a_r4_block_zero: assert (bus_out == '0)
                else $error("R4 block not zero");
        end
    end
endmodule

bind combo_shift_unit shift_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .alu_res         (alu_res),
    .shift_op        (shift_op),
    .fill_from_carry (fill_from_carry),
    .carry_in        (carry_in),
    .bus_out         (bus_out)
);

// File: tb/tb_combo_shift_unit.sv
module tb_combo_shift_unit;
    localparam int W = 8;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] alu_res = '0;
    logic [1:0]   shift_op = 2'b00;
    logic         fill_from_carry = 1'b0;
    logic         carry_in = 1'b0;
    logic [W-1:0] bus_out;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    combo_shift_unit #(.WIDTH(W)) dut (
        .alu_res         (alu_res),
        .shift_op        (shift_op),
        .fill_from_carry (fill_from_carry),
        .carry_in        (carry_in),
        .bus_out         (bus_out)
    );

    function automatic int model(int f, int op, int h2, int c);
        int fill;
        fill = (h2 != 0 && c != 0) ? 1 : 0;
        case (op)
            0: return f;
            1: return (f / 2) + fill * (1 << (W - 1));
            2: return ((f * 2) + fill) % (1 << W);
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, int exp);
        total++;
        if (int'(bus_out) != exp) begin
            bad++;
            $display("FAIL %s: f=%0h op=%0d h2=%0d c=%0d actual=%0h expected=%0h",
                     tag, alu_res, shift_op, fill_from_carry, carry_in, bus_out, exp);
        end
    endtask

    task automatic apply(int f, int op, int h2, int c, string tag);
        @(negedge clk);
        alu_res = W'(f & MASK);
        shift_op = 2'(op);
        fill_from_carry = 1'(h2);
        carry_in = 1'(c);
        #5;
        check(tag, model(f & MASK, op, h2, c));
    endtask

    initial begin
        #4000000;
        $display("FAIL watchdog: actual=timeout expected=finish");
        bad++;
        total++;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        check("R1 reset state", 0);
        rst = 1'b0;

        // Directed end-bit and pattern cases
        apply(8'h80, 1, 0, 1, "R2 msb moves down, R5 zero fill");
        apply(8'h01, 1, 0, 1, "R2 lsb discarded");
        apply(8'h01, 2, 0, 1, "R3 lsb moves up, R5 zero fill");
        apply(8'h80, 2, 0, 1, "R3 msb discarded");
        apply(8'h55, 1, 1, 1, "R6 carry into msb on right");
        apply(8'h55, 2, 1, 1, "R6 carry into lsb on left");
        apply(8'hAA, 2, 1, 0, "R6 carry zero into lsb");
        apply(8'hFF, 3, 1, 1, "R4 block all ones");
        apply(8'h3C, 0, 1, 1, "R7 pass ignores fill");
        apply(8'h3C, 0, 0, 0, "R7 pass ignores fill");
        apply(8'hC3, 3, 0, 0, "R7 block ignores fill");
        apply(8'hC3, 3, 1, 1, "R7 block ignores fill");
        apply(8'h55, 1, 1, 1, "R8 repeat gives same output");

        // Exhaustive sweep over words, codes and fill controls
        for (int f = 0; f < (1 << W); f++) begin
            for (int op = 0; op < 4; op++) begin
                for (int s = 0; s < 4; s++) begin
                    string tag;
                    case (op)
                        0: tag = "R1 sweep pass";
                        1: tag = (s == 3) ? "R6 sweep right" : "R2 sweep right";
                        2: tag = (s == 3) ? "R6 sweep left" : "R3 sweep left";
                        default: tag = "R4 sweep block";
                    endcase
                    apply(f, op, s / 2, s % 2, tag);
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule